// File: doc/BRIEF.md
# Event Preprocessing and Timestamp Unit

This unit is the real-time front end of a hardware monitor. It watches up to 30 probed target signals. For each signal it synchronises the input, finds its rising and falling transitions, and turns them into events according to a per-event enable and edge choice. Every event has its own saturating occurrence counter. A free-running global timestamp advances once per monitoring clock. A one-cycle trigger pulse and a vector of the events that fired go out every cycle in which any enabled event occurs.

Toward the trace buffer the unit offers a sample stream carrying the timestamp of the detection cycle and the event vector. There are two qualification modes. In per-event mode a sample is produced on each cycle with an event. In window mode a start event opens a capture window, a sample is produced on every cycle while the window is open, and a stop event closes it.

The sample stream uses valid/ready. A sample that is not accepted is held stable until `smp_ready` is seen high. The monitor cannot stall the target, so any sample qualified while one is held is discarded. The sink is expected to keep `smp_ready` high during capture.

The unit also divides the monitoring clock by a programmable ratio and emits a target clock enable. This keeps every target transition several monitor cycles long. Settings are written through a simple write-only register port.

Top module: `evt_monitor_top`

## Requirements
- R1: Each probe passes through two synchronising flops before edge detection. A transition on `probe[i]` placed before rising edge k is reported by `trig` and `evt_vec[i]` after rising edge k+2, for exactly one cycle per detected transition.
- R2: A write with `cfg_addr` equal to an event index i (0 to 29) sets that event's enable from `cfg_wdata[0]` and its edge code from `cfg_wdata[2:1]`. The edge codes are 2'b01 rising only, 2'b10 falling only, 2'b11 both, and 2'b00 none.
- R3: An event whose enable is 0 never raises `trig` or its `evt_vec` bit, and never changes its counter. All events reset to disabled.
- R4: `trig` is high in exactly the cycles in which `evt_vec` is nonzero.
- R5: Each event has a 16-bit counter that increments once per detected event and stays at 16'hFFFF once reached. Driving `cnt_sel` with an event index shows that counter on `cnt_val` in the same cycle.
- R6: A write to address 33 clears all counters at that clock edge. The clear wins over a simultaneous increment.
- R7: `ts_out` resets to 0 and increases by one every monitoring clock, wrapping modulo 2^32.
- R8: A write to address 32 selects the mode with `cfg_wdata[0]` (0 per-event, 1 window), the start event index with `cfg_wdata[5:1]` and the stop event index with `cfg_wdata[10:6]`. The reset value is per-event mode. In per-event mode a sample is offered in the same cycle as `trig`, with `smp_evts` equal to `evt_vec` and `smp_ts` equal to `ts_out - 1`.
- R9: In window mode, the cycle with the start event is sampled, and every following cycle is sampled up to and including the cycle with the stop event. A stop event while the window is closed produces no sample. When start and stop fire in the same cycle, that cycle is sampled and the window stays closed afterwards.
- R10: While `smp_valid` is high and `smp_ready` is low, `smp_valid`, `smp_ts` and `smp_evts` hold. Samples qualified during that time are dropped, and none is delivered after the held one is taken.
- R11: `tclk_en` pulses once every ratio+1 monitoring cycles. The ratio resets to 1 and is set from `cfg_wdata[7:0]` by a write to address 34, which also restarts the division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitoring clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe | input | 30 | Probed target signals |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cnt_sel | input | 5 | Event index whose counter is shown |
| cnt_val | output | 16 | Selected event counter |
| trig | output | 1 | One-cycle pulse when any event fires |
| evt_vec | output | 30 | Events that fired, aligned with trig |
| ts_out | output | 32 | Global timestamp |
| smp_valid | output | 1 | Sample stream valid |
| smp_ready | input | 1 | Sample stream ready |
| smp_ts | output | 32 | Timestamp of the sampled detection cycle |
| smp_evts | output | 30 | Event vector of the sampled cycle |
| tclk_en | output | 1 | Target clock enable pulse |

## Verification
The hardest state to reach is counter saturation. It needs 65,535 qualified events on a single channel. The stimulus sets one event to both edges and toggles its probe on every cycle, so the counter gains one per clock and passes the limit in about 65.5k cycles. The window's stop-wins case also needs care, because the start and stop detections must fall in the same cycle. Both probes are therefore lowered together and then raised at the same falling clock edge, which lets them pass the synchronisers in lockstep.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic {
    SMP_EACH   = 1'b0,
    SMP_WINDOW = 1'b1
  } smp_mode_e;

  localparam int unsigned ADDR_MODE = 32;
  localparam int unsigned ADDR_CLR  = 33;
  localparam int unsigned ADDR_DIV  = 34;
endpackage

// File: rtl/evt_detect.sv
module evt_detect
  import evt_mon_pkg::*;
#(
  parameter int N_EVT = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] probe,
  input  logic [N_EVT-1:0] cfg_wr,
  input  logic [2:0]       cfg_bits,
  output logic [N_EVT-1:0] evt_c,
  output logic [N_EVT-1:0] evt_q,
  output logic             trig_q
);
  generate
    for (genvar i = 0; i < N_EVT; i++) begin : g_ch
      logic      s1, s2, prev, en;
      edge_sel_e sel;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s1   <= 1'b0;
          s2   <= 1'b0;
          prev <= 1'b0;
          en   <= 1'b0;
          sel  <= EDGE_NONE;
        end else begin
          s1   <= probe[i];
          s2   <= s1;
          prev <= s2;
          if (cfg_wr[i]) begin
            en  <= cfg_bits[0];
            sel <= edge_sel_e'(cfg_bits[2:1]);
          end
        end
      end

      // rising edge uses code bit 0, falling edge uses code bit 1
      assign evt_c[i] = en & ((sel[0] & s2 & ~prev) | (sel[1] & ~s2 & prev));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      evt_q  <= evt_c;
      trig_q <= |evt_c;
    end
  end
endmodule

// File: rtl/evt_counters.sv
module evt_counters #(
  parameter int N_EVT = 30,
  parameter int CNT_W = 16,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N_EVT-1:0] evt,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt [N_EVT];

  generate
    for (genvar i = 0; i < N_EVT; i++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n || clr)
          cnt[i] <= '0;
        else if (evt[i] && cnt[i] != CNT_MAX)
          cnt[i] <= cnt[i] + CNT_W'(1);
      end
    end
  endgenerate

  always_comb begin
    cnt_val = '0;
    for (int i = 0; i < N_EVT; i++)
      if (sel == SEL_W'(i)) cnt_val = cnt[i];
  end
endmodule

// File: rtl/smp_qual.sv
module smp_qual
  import evt_mon_pkg::*;
#(
  parameter int N_EVT = 30,
  parameter int TS_W  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_c,
  input  logic [TS_W-1:0]  ts,
  input  smp_mode_e        mode,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] stop_idx,
  input  logic             smp_ready,
  output logic             smp_valid,
  output logic [TS_W-1:0]  smp_ts,
  output logic [N_EVT-1:0] smp_evts
);
  logic start_hit, stop_hit, win_q, win_d, take;

  assign start_hit = |((evt_c >> start_idx) & N_EVT'(1));
  assign stop_hit  = |((evt_c >> stop_idx) & N_EVT'(1));

  always_comb begin
    if (mode == SMP_WINDOW) begin
      take  = win_q | start_hit;
      win_d = stop_hit ? 1'b0 : (start_hit ? 1'b1 : win_q);
    end else begin
      take  = |evt_c;
      win_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q     <= 1'b0;
      smp_valid <= 1'b0;
      smp_ts    <= '0;
      smp_evts  <= '0;
    end else begin
      win_q <= win_d;
      // a held sample blocks newer ones, which are dropped
      if (!smp_valid || smp_ready) begin
        smp_valid <= take;
        if (take) begin
          smp_ts   <= ts;
          smp_evts <= evt_c;
        end
      end
    end
  end
endmodule

// File: rtl/clk_div.sv
module clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ratio_wr,
  input  logic [DIV_W-1:0] ratio_in,
  output logic             tclk_en
);
  logic [DIV_W-1:0] ratio_q, cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= DIV_W'(1);
      cnt_q   <= '0;
      tclk_en <= 1'b0;
    end else if (ratio_wr) begin
      ratio_q <= ratio_in;
      cnt_q   <= '0;
      tclk_en <= 1'b0;
    end else if (cnt_q >= ratio_q) begin
      cnt_q   <= '0;
      tclk_en <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + DIV_W'(1);
      tclk_en <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_monitor_top.sv
module evt_monitor_top
  import evt_mon_pkg::*;
#(
  parameter int N_EVT  = 30,
  parameter int CNT_W  = 16,
  parameter int TS_W   = 32,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(N_EVT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  probe,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [IDX_W-1:0]  cnt_sel,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              trig,
  output logic [N_EVT-1:0]  evt_vec,
  output logic [TS_W-1:0]   ts_out,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [TS_W-1:0]   smp_ts,
  output logic [N_EVT-1:0]  smp_evts,
  output logic              tclk_en
);
  logic [N_EVT-1:0] cfg_wr, evt_c;
  logic             wr_mode, wr_clr, wr_div;
  smp_mode_e        mode_q;
  logic [IDX_W-1:0] start_q, stop_q;
  logic [TS_W-1:0]  ts_q;

  always_comb begin
    for (int i = 0; i < N_EVT; i++)
      cfg_wr[i] = cfg_we && (cfg_addr == ADDR_W'(i));
  end

  assign wr_mode = cfg_we && (cfg_addr == ADDR_W'(ADDR_MODE));
  assign wr_clr  = cfg_we && (cfg_addr == ADDR_W'(ADDR_CLR));
  assign wr_div  = cfg_we && (cfg_addr == ADDR_W'(ADDR_DIV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= SMP_EACH;
      start_q <= '0;
      stop_q  <= IDX_W'(1);
      ts_q    <= '0;
    end else begin
      ts_q <= ts_q + TS_W'(1);
      if (wr_mode) begin
        mode_q  <= smp_mode_e'(cfg_wdata[0]);
        start_q <= cfg_wdata[IDX_W:1];
        stop_q  <= cfg_wdata[2*IDX_W:IDX_W+1];
      end
    end
  end

  assign ts_out = ts_q;

  evt_detect #(.N_EVT(N_EVT)) u_det (
    .clk(clk), .rst_n(rst_n), .probe(probe), .cfg_wr(cfg_wr),
    .cfg_bits(cfg_wdata[2:0]), .evt_c(evt_c), .evt_q(evt_vec), .trig_q(trig)
  );

  evt_counters #(.N_EVT(N_EVT), .CNT_W(CNT_W), .SEL_W(IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(wr_clr), .evt(evt_c),
    .sel(cnt_sel), .cnt_val(cnt_val)
  );

  smp_qual #(.N_EVT(N_EVT), .TS_W(TS_W), .IDX_W(IDX_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .evt_c(evt_c), .ts(ts_q), .mode(mode_q),
    .start_idx(start_q), .stop_idx(stop_q), .smp_ready(smp_ready),
    .smp_valid(smp_valid), .smp_ts(smp_ts), .smp_evts(smp_evts)
  );

  clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .ratio_wr(wr_div),
    .ratio_in(cfg_wdata[DIV_W-1:0]), .tclk_en(tclk_en)
  );
endmodule

// File: rtl/evt_monitor_chk.sv
module evt_monitor_chk #(
  parameter int N_EVT = 30,
  parameter int TS_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic [N_EVT-1:0] evt_vec,
  input logic [TS_W-1:0]  ts_out,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [TS_W-1:0]  smp_ts,
  input logic [N_EVT-1:0] smp_evts
);
  p_ts_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ts_out == $past(ts_out) + TS_W'(1));

  p_trig_has_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (evt_vec != '0));

  p_vec_has_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |-> trig);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_ts) && $stable(smp_evts)));

  p_fresh_ts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && smp_valid && (!$past(smp_valid) || $past(smp_ready)))
      |-> smp_ts == ts_out - TS_W'(1));
endmodule

bind evt_monitor_top evt_monitor_chk #(.N_EVT(N_EVT), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .evt_vec(evt_vec), .ts_out(ts_out),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_ts(smp_ts),
  .smp_evts(smp_evts)
);

// File: tb/tb_evt_monitor_top.sv
module tb_evt_monitor_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] probe = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [4:0]  cnt_sel = '0;
  logic [15:0] cnt_val;
  logic        trig;
  logic [29:0] evt_vec;
  logic [31:0] ts_out;
  logic        smp_valid;
  logic        smp_ready = 1'b1;
  logic [31:0] smp_ts;
  logic [29:0] smp_evts;
  logic        tclk_en;

  int n_tests = 0;
  int n_fail  = 0;
  int trig_tot = 0;
  int smp_tot  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_monitor_top dut (
    .clk(clk), .rst_n(rst_n), .probe(probe), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cnt_sel(cnt_sel),
    .cnt_val(cnt_val), .trig(trig), .evt_vec(evt_vec), .ts_out(ts_out),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_ts(smp_ts),
    .smp_evts(smp_evts), .tclk_en(tclk_en)
  );

  // fields: [15:11] index, [10] enable, [9:8] edge code, [1:0] expected count
  localparam logic [15:0] VEC [6] = '{
    {5'd4,  1'b1, 2'b01, 6'd0, 2'd1},
    {5'd5,  1'b1, 2'b10, 6'd0, 2'd1},
    {5'd6,  1'b1, 2'b11, 6'd0, 2'd2},
    {5'd7,  1'b1, 2'b00, 6'd0, 2'd0},
    {5'd8,  1'b0, 2'b11, 6'd0, 2'd0},
    {5'd29, 1'b1, 2'b11, 6'd0, 2'd2}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      if (trig) trig_tot++;
      if (smp_valid && smp_ready) smp_tot++;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_cnt(input int idx, output logic [15:0] v);
    cnt_sel = 5'(idx);
    #1;
    v = cnt_val;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] t0, held_ts;
    int s0, g0, gap;

    repeat (3) @(negedge clk);
    // reset state: R7, R4, R8, R5
    check("R7 reset ts", ts_out, 0);
    check("R4 reset trig", trig, 0);
    check("R8 reset valid", smp_valid, 0);
    read_cnt(0, v);
    check("R5 reset cnt", v, 0);
    rst_n = 1'b1;

    // R7: timestamp steps once per cycle
    @(negedge clk);
    t0 = ts_out;
    repeat (10) @(negedge clk);
    check("R7 ts step", ts_out, t0 + 10);

    // R1 latency, R8 per-event sample
    wr(6'd9, 16'b011);
    @(negedge clk); probe[9] = 1'b1;
    @(negedge clk); check("R1 no early trig 1", trig, 0);
    @(negedge clk); check("R1 no early trig 2", trig, 0);
    @(negedge clk);
    check("R1 trig at edge k+2", trig, 1);
    check("R1 evt bit", evt_vec, 30'(1) << 9);
    check("R8 sample valid", smp_valid, 1);
    check("R8 sample evts", smp_evts, 30'(1) << 9);
    check("R8 sample ts", smp_ts, ts_out - 1);
    @(negedge clk); check("R1 one-cycle pulse", trig, 0);
    read_cnt(9, v);
    check("R5 count one", v, 1);

    // table: R2 edge codes, R3 disabled channel
    for (int k = 0; k < 6; k++) begin
      int idx;
      idx = int'(VEC[k][15:11]);
      wr(6'(idx), {13'd0, VEC[k][9:8], VEC[k][10]});
      g0 = trig_tot;
      @(negedge clk); probe[idx] = 1'b1;
      repeat (4) @(negedge clk);
      probe[idx] = 1'b0;
      repeat (5) @(negedge clk);
      read_cnt(idx, v);
      check(VEC[k][10] ? "R2 edge code count" : "R3 disabled count", v, VEC[k][1:0]);
      check(VEC[k][10] ? "R2 edge code trig" : "R3 disabled trig", trig_tot - g0, VEC[k][1:0]);
    end

    // R5 saturation
    wr(6'd3, 16'b111);
    for (int n = 0; n < 65540; n++) begin
      @(negedge clk); probe[3] = ~probe[3];
    end
    repeat (5) @(negedge clk);
    read_cnt(3, v);
    check("R5 saturate", v, 16'hFFFF);
    // R6 clear
    wr(6'd33, 16'd0);
    read_cnt(3, v);
    check("R6 clear", v, 0);
    read_cnt(9, v);
    check("R6 clear other", v, 0);

    // R9 window: start event 0, stop event 1, both rising
    wr(6'd0, 16'b011);
    wr(6'd1, 16'b011);
    wr(6'd32, {5'd0, 5'd1, 5'd0, 1'b1});
    s0 = smp_tot;
    @(negedge clk); probe[0] = 1'b1;
    repeat (5) @(negedge clk);
    probe[1] = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 window span", smp_tot - s0, 6);
    s0 = smp_tot;
    probe[1] = 1'b0;
    repeat (3) @(negedge clk);
    probe[1] = 1'b1;
    repeat (8) @(negedge clk);
    check("R9 stop while closed", smp_tot - s0, 0);
    probe[0] = 1'b0; probe[1] = 1'b0;
    repeat (4) @(negedge clk);
    s0 = smp_tot;
    probe[0] = 1'b1; probe[1] = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 stop wins", smp_tot - s0, 1);

    // R10 back-pressure in per-event mode
    wr(6'd32, 16'd0);
    wr(6'd2, 16'b111);
    smp_ready = 1'b0;
    @(negedge clk); probe[2] = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 held valid", smp_valid, 1);
    held_ts = smp_ts;
    probe[2] = 1'b0;
    repeat (2) @(negedge clk);
    probe[2] = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 still valid", smp_valid, 1);
    check("R10 ts stable", smp_ts, held_ts);
    smp_ready = 1'b1;
    @(negedge clk);
    check("R10 newer dropped", smp_valid, 0);

    // R11 divider, default ratio then ratio 3
    while (!tclk_en) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tclk_en);
    check("R11 default period", gap, 2);
    wr(6'd34, 16'd3);
    while (!tclk_en) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tclk_en);
    check("R11 ratio 3 period", gap, 4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule